// File: doc/BRIEF.md
# SDRAM Column Burst Engine

This block executes the column phase of a single-data-rate SDRAM-style memory. Each clock it may take a READ or WRITE column command carrying a bank and a starting column. It walks the burst's column addresses and stores write words into a small internal array. Read words go into a latency pipeline, so each one reaches the read-data port a programmable number of cycles (the CAS latency) after it was fetched. A column command that arrives while a burst is running ends that burst at once, and the new access takes over in the same cycle. Read words already fetched still come out at their own latency.

Control is a three-state machine. `ST_IDLE` means no burst is running. `ST_RD` means a read burst is fetching its remaining words. `ST_WR` means a write burst is storing its remaining words. The transitions are:
- **start**: any state goes to `ST_RD` or `ST_WR` when a command with burst length above one arrives.
- **single**: any state goes to `ST_IDLE` when a command with burst length one arrives.
- **continue**: the machine stays in `ST_RD` or `ST_WR` while words remain.
- **finish**: `ST_RD` or `ST_WR` goes to `ST_IDLE` after the last word.
- **interrupt**: a new command in `ST_RD` or `ST_WR` is a start or single transition that drops the old burst's remaining words.

Top module: `sdram_col_engine`

## Requirements
- R1: While reset is low, and after it is released, `rvalid_o` is 0, `rdata_o` is 0 and the engine is idle.
- R2: A READ (`cmd_i` = 2'b01) fetches word 0 in its own cycle. That word is on `rdata_o` with `rvalid_o` high exactly L cycles after the command, where L is 2 when `lat_sel_i` = 0 and 3 when `lat_sel_i` = 1.
- R3: The burst length is 1, 2, 4 or 8 for `bl_sel_i` = 0, 1, 2 or 3. The words of a burst are fetched or stored on consecutive cycles, with no gaps.
- R4: Word i of a burst that starts at column c uses column (c with its low log2(BL) bits cleared) OR ((c + i) mod BL). The address therefore wraps inside the aligned block of BL columns.
- R5: A WRITE (`cmd_i` = 2'b10) stores `wdata_i` of the command cycle as word 0, and stores `wdata_i` of each following cycle as the next word of the burst.
- R6: A READ or WRITE that arrives during a burst drops that burst's remaining words, and its own word 0 is handled in that same cycle. Commands on consecutive cycles are all accepted. Codes 2'b00 and 2'b11 are no-ops.
- R7: When a READ interrupts a READ, the words fetched before the interruption still come out at their latency. The new burst's words follow them with no gap.
- R8: When a READ interrupts a WRITE, `wdata_i` is not stored from the READ's cycle onward.
- R9: A READ issued on the cycle after the last write word returns the data just written.
- R10: `rdata_o` is zero on every cycle where `rvalid_o` is low.
- R11: `lat_sel_i` and `bl_sel_i` take effect only when the engine is idle and no read word is pending in the latency pipeline. A change at any other time, including a command that interrupts a burst, is ignored until that condition holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_i | input | 2 | Column command: 00 no-op, 01 READ, 10 WRITE, 11 no-op |
| bank_i | input | BANK_W | Bank of the command |
| col_i | input | COL_W | Starting column of the command |
| wdata_i | input | DATA_W | Write word for the current cycle |
| lat_sel_i | input | 1 | CAS latency select: 0 gives 2 cycles, 1 gives 3 |
| bl_sel_i | input | 2 | Burst length select: 1, 2, 4, 8 |
| rdata_o | output | DATA_W | Read word, zero when not valid |
| rvalid_o | output | 1 | High on each cycle that carries a read word |

## Verification
The bench sweeps every latency, burst length and start column. For each combination it writes a burst and then reads it back at once. A wrong wrap mask would spill words into the next block, and an off-by-one in the pipeline would shift every read word by a cycle. The bench then cuts each kind of burst with each kind of command at every possible word, so a design that let the old burst finish would store stray write words or emit extra read words. A final case changes the mode inputs mid-burst. A design that sampled them at any time would change that burst's length, or would make two read words collide in the pipeline.

// File: rtl/sdram_col_pkg.sv
package sdram_col_pkg;

    typedef enum logic [1:0] {
        CMD_NOP = 2'b00,
        CMD_RD  = 2'b01,
        CMD_WR  = 2'b10,
        CMD_RSV = 2'b11
    } col_cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_RD   = 2'b01,
        ST_WR   = 2'b10
    } burst_state_e;

    // Burst length from its 2-bit select code.
    function automatic logic [3:0] burst_len(input logic [1:0] code);
        return 4'd1 << code;
    endfunction

endpackage

// File: rtl/sdram_burst_addr.sv
module sdram_burst_addr #(
    parameter int COL_W = 4
) (
    input  logic [COL_W-1:0] base_i,
    input  logic [3:0]       idx_i,
    input  logic [3:0]       len_i,
    output logic [COL_W-1:0] col_o
);
    logic [COL_W-1:0] mask;
    logic [COL_W-1:0] sum;

    always_comb begin
        mask  = COL_W'(len_i - 4'd1);
        sum   = base_i + COL_W'(idx_i);
        col_o = (base_i & ~mask) | (sum & mask);
    end

    initial begin
        assert (COL_W >= 3) else $error("column width too small for 8-word bursts");
    end
endmodule

// File: rtl/sdram_rd_pipe.sv
module sdram_rd_pipe #(
    parameter int DATA_W  = 8,
    parameter int MAX_LAT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic [1:0]        lat_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              rvalid_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              busy_o
);
    logic [MAX_LAT-1:0] vld_q;
    logic [DATA_W-1:0]  dat_q [MAX_LAT];

    // Each word enters at stage lat-1 and shifts toward stage 0 (the output).
    for (genvar s = 0; s < MAX_LAT; s++) begin : g_stage
        logic hit;
        assign hit = push_i && (lat_i == 2'(s + 1));
        if (s < MAX_LAT - 1) begin : g_mid
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    vld_q[s] <= 1'b0;
                    dat_q[s] <= '0;
                end else if (hit) begin
                    vld_q[s] <= 1'b1;
                    dat_q[s] <= data_i;
                end else begin
                    vld_q[s] <= vld_q[s+1];
                    dat_q[s] <= vld_q[s+1] ? dat_q[s+1] : '0;
                end
            end

            // The slot a new word lands in must not be claimed by an older word.
            assert_slot_free_R11: assert property (@(posedge clk) disable iff (!rst_n)
                hit |-> !vld_q[s+1]);
        end else begin : g_top
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    vld_q[s] <= 1'b0;
                    dat_q[s] <= '0;
                end else begin
                    vld_q[s] <= hit;
                    dat_q[s] <= hit ? data_i : '0;
                end
            end
        end
    end

    assign rvalid_o = vld_q[0];
    assign rdata_o  = dat_q[0];
    assign busy_o   = |vld_q;

    assert_quiet_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rvalid_o |-> rdata_o == '0);
endmodule

// File: rtl/sdram_col_engine.sv
module sdram_col_engine
    import sdram_col_pkg::*;
#(
    parameter int BANK_W = 2,
    parameter int COL_W  = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cmd_i,
    input  logic [BANK_W-1:0] bank_i,
    input  logic [COL_W-1:0]  col_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              lat_sel_i,
    input  logic [1:0]        bl_sel_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              rvalid_o
);
    localparam int ADDR_W = BANK_W + COL_W;
    localparam int DEPTH  = 1 << ADDR_W;

    burst_state_e      state_q, state_d;
    logic [3:0]        cnt_q, cnt_d;
    logic [BANK_W-1:0] bank_q, bank_d;
    logic [COL_W-1:0]  base_q, base_d;
    logic              lat_q;
    logic [1:0]        bl_q;

    logic              open_mode, eff_lat, is_rd, is_wr, pipe_busy;
    logic [1:0]        eff_bl;
    logic [3:0]        cur_len, iss_idx;
    logic [BANK_W-1:0] iss_bank;
    logic [COL_W-1:0]  iss_base, iss_col;
    logic              iss_rd, iss_wr;
    logic [DATA_W-1:0] mem_q [DEPTH];

    // Next-state and issue logic.
    always_comb begin
        open_mode = (state_q == ST_IDLE) && !pipe_busy;
        eff_lat   = open_mode ? lat_sel_i : lat_q;
        eff_bl    = open_mode ? bl_sel_i  : bl_q;
        cur_len   = burst_len(eff_bl);
        is_rd     = (cmd_i == CMD_RD);
        is_wr     = (cmd_i == CMD_WR);

        state_d  = state_q;
        cnt_d    = cnt_q;
        bank_d   = bank_q;
        base_d   = base_q;
        iss_bank = bank_q;
        iss_base = base_q;
        iss_idx  = cnt_q;
        iss_rd   = 1'b0;
        iss_wr   = 1'b0;

        if (is_rd || is_wr) begin
            iss_bank = bank_i;
            iss_base = col_i;
            iss_idx  = 4'd0;
            iss_rd   = is_rd;
            iss_wr   = is_wr;
            bank_d   = bank_i;
            base_d   = col_i;
            if (cur_len > 4'd1) begin
                state_d = is_rd ? ST_RD : ST_WR;
                cnt_d   = 4'd1;
            end else begin
                state_d = ST_IDLE;
                cnt_d   = 4'd0;
            end
        end else begin
            unique case (state_q)
                ST_IDLE: ;
                ST_RD, ST_WR: begin
                    iss_rd = (state_q == ST_RD);
                    iss_wr = (state_q == ST_WR);
                    if (cnt_q == cur_len - 4'd1) begin
                        state_d = ST_IDLE;
                        cnt_d   = 4'd0;
                    end else begin
                        cnt_d = cnt_q + 4'd1;
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            bank_q  <= '0;
            base_q  <= '0;
            lat_q   <= 1'b0;
            bl_q    <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            bank_q  <= bank_d;
            base_q  <= base_d;
            lat_q   <= eff_lat;
            bl_q    <= eff_bl;
        end
    end

    sdram_burst_addr #(.COL_W(COL_W)) u_addr (
        .base_i (iss_base),
        .idx_i  (iss_idx),
        .len_i  (cur_len),
        .col_o  (iss_col)
    );

    always_ff @(posedge clk) begin
        if (iss_wr) begin
            mem_q[{iss_bank, iss_col}] <= wdata_i;
        end
    end

    sdram_rd_pipe #(.DATA_W(DATA_W), .MAX_LAT(3)) u_pipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_i   (iss_rd),
        .lat_i    (eff_lat ? 2'd3 : 2'd2),
        .data_i   (mem_q[{iss_bank, iss_col}]),
        .rvalid_o (rvalid_o),
        .rdata_o  (rdata_o),
        .busy_o   (pipe_busy)
    );

    assert_len_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |-> (cnt_q != 4'd0) && (cnt_q < burst_len(bl_q)));

    assert_mode_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> $stable(bl_q) && $stable(lat_q));

    assert_restart_wr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_WR && burst_len(eff_bl) > 4'd1) |=> (state_q == ST_WR && cnt_q == 4'd1));

    assert_restart_rd_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_RD && burst_len(eff_bl) > 4'd1) |=> (state_q == ST_RD && cnt_q == 4'd1));

    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (state_q == ST_IDLE && !rvalid_o));
endmodule

// File: tb/sdram_col_engine_tb.sv
module sdram_col_engine_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] cmd = 2'b00;
    logic [1:0] bank = '0;
    logic [3:0] colv = '0;
    logic [7:0] wdata = '0;
    logic       tb_lat = 1'b0;
    logic [1:0] tb_bl = 2'd0;
    logic [7:0] rdata;
    logic       rvalid;

    always #5 clk = ~clk;

    sdram_col_engine u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_i(cmd), .bank_i(bank), .col_i(colv),
        .wdata_i(wdata), .lat_sel_i(tb_lat), .bl_sel_i(tb_bl),
        .rdata_o(rdata), .rvalid_o(rvalid)
    );

    int errors = 0;
    int checks = 0;
    int n = 0;
    string tag = "R1";

    // Reference model state, built from the requirements.
    int m_state = 0;     // 0 idle, 1 read burst, 2 write burst
    int m_bank, m_base, m_cnt;
    int m_len = 1;
    int m_cl = 2;
    int lastvis = -10;
    logic [7:0] shadow [64];
    bit         exp_v [1024];
    logic [7:0] exp_d [1024];
    int wseq = 0;

    task automatic check_out();
        int i = n % 1024;
        logic [7:0] ed = exp_v[i] ? exp_d[i] : 8'h00;
        checks++;
        if (rvalid !== exp_v[i] || rdata !== ed) begin
            errors++;
            $display("FAIL %s%s: rvalid=%0b rdata=%02h expected rvalid=%0b rdata=%02h at cycle %0d",
                     tag, (!exp_v[i] && rvalid === 1'b0) ? " R10" : "",
                     rvalid, rdata, exp_v[i], ed, n);
        end
        exp_v[i] = 1'b0;
    endtask

    task automatic model_edge(input logic [1:0] c, input int b, input int col, input logic [7:0] wd);
        bit open = (m_state == 0) && (lastvis < n);
        bit rd = 0, wr = 0;
        int idx = 0, cw, a, v;
        if (open) begin
            m_cl  = tb_lat ? 3 : 2;
            m_len = 1 << tb_bl;
        end
        if (c == 2'b01 || c == 2'b10) begin
            rd = (c == 2'b01); wr = (c == 2'b10);
            m_bank = b; m_base = col; idx = 0;
            m_state = (m_len > 1) ? (rd ? 1 : 2) : 0;
            m_cnt = 1;
        end else if (m_state != 0) begin
            rd = (m_state == 1); wr = (m_state == 2);
            idx = m_cnt;
            if (m_cnt == m_len - 1) m_state = 0;
            else m_cnt++;
        end
        if (rd || wr) begin
            cw = (m_base - (m_base % m_len)) + ((m_base + idx) % m_len);
            a = m_bank * 16 + cw;
            if (wr) shadow[a] = wd;
            if (rd) begin
                v = n + m_cl;
                exp_v[v % 1024] = 1'b1;
                exp_d[v % 1024] = shadow[a];
                lastvis = v;
            end
        end
    endtask

    task automatic step(input logic [1:0] c, input int b, input int col);
        logic [7:0] wd;
        wseq++;
        wd = 8'((wseq * 29 + 7) ^ (wseq >> 3));
        check_out();
        cmd = c; bank = 2'(b); colv = 4'(col); wdata = wd;
        model_edge(c, b, col, wd);
        @(posedge clk);
        n++;
        @(negedge clk);
    endtask

    task automatic idle(input int k);
        for (int j = 0; j < k; j++) step(2'b00, 0, 0);
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) begin exp_v[i] = 1'b0; exp_d[i] = 8'h00; end
        for (int i = 0; i < 64; i++) shadow[i] = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (rvalid !== 1'b0 || rdata !== 8'h00) begin
            errors++;
            $display("FAIL R1 in reset: rvalid=%0b rdata=%02h expected 0 00", rvalid, rdata);
        end
        rst_n = 1'b1;
        n = 0;
        tag = "R1";
        idle(2);

        // Preload all 64 words with single-word writes (R5).
        tag = "R5";
        tb_bl = 2'd0;
        for (int a = 0; a < 64; a++) step(2'b10, a / 16, a % 16);
        idle(2);

        // Sweep latency, length, start column: write burst then immediate read.
        tag = "R2 R3 R4 R5 R9";
        for (int l = 0; l < 2; l++)
            for (int bl = 0; bl < 4; bl++)
                for (int c0 = 0; c0 < 16; c0++) begin
                    tb_lat = l[0]; tb_bl = 2'(bl);
                    idle(4);
                    step(2'b10, c0 % 4, c0);
                    idle((1 << bl) - 1);
                    step(2'b01, c0 % 4, c0);
                    idle((1 << bl) + 4);
                end

        // Interrupt every burst kind with every command kind at every word.
        tag = "R6 R7 R8";
        for (int l = 0; l < 2; l++)
            for (int bl = 1; bl < 4; bl++)
                for (int k1 = 1; k1 < 3; k1++)
                    for (int k2 = 1; k2 < 3; k2++)
                        for (int cut = 1; cut < (1 << bl); cut++) begin
                            tb_lat = l[0]; tb_bl = 2'(bl);
                            idle(5);
                            step(2'(k1), cut % 4, (cut * 3) % 16);
                            idle(cut - 1);
                            step(2'(k2), (cut + 1) % 4, (cut * 5 + 2) % 16);
                            idle((1 << bl) - 1);
                            step(2'b01, cut % 4, (cut * 3) % 16);
                            idle((1 << bl) + 4);
                        end

        // Reserved code and no-ops leave the array untouched (R6).
        tag = "R6";
        tb_lat = 1'b0; tb_bl = 2'd2;
        idle(4);
        step(2'b11, 1, 4);
        step(2'b11, 1, 5);
        step(2'b01, 1, 4);
        idle(8);

        // Mode inputs changed mid-burst are ignored until the engine drains (R11).
        tag = "R11";
        tb_lat = 1'b0; tb_bl = 2'd2;
        idle(4);
        step(2'b01, 2, 9);
        tb_lat = 1'b1; tb_bl = 2'd3;
        step(2'b00, 0, 0);
        step(2'b01, 3, 2);
        idle(1);
        step(2'b00, 0, 0);
        idle(8);
        step(2'b01, 2, 9);
        idle(12);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule